// File: doc/BRIEF.md
# Per-Queue Selectable Interrupt Aggregator

This block collects per-queue status conditions from a 64-queue manager into two interrupt lines. `irq_lo_o` serves queues 0 to 31 and `irq_hi_o` serves queues 32 to 63. Each lower-half queue has a 3-bit source code that picks one of its four status flags and can invert that flag. Upper-half queues always trigger when the queue is no longer nearly empty.

Each half keeps an enable bitmap and a pending bitmap. A pending bit latches while its queue is enabled and its condition holds. Software clears pending bits by writing ones to them. A simple register port carries the writes and gives combinational reads. The block holds no queue storage; the status flags arrive as inputs.

Top module: `qirq_agg`

## Requirements
- R1: After reset, every source code, enable bit and pending bit reads zero, and both interrupt lines are low.
- R2: A lower-half queue's condition is its status flag selected by source bits 1:0 (0 empty, 1 nearly empty, 2 nearly full, 3 full; flag k is `stat_lo_i[4q+k]`), inverted when source bit 2 is set. Code 7 therefore means not full.
- R3: For upper-half queue 32+i, the condition is `ne_hi_i[i]` low (not nearly empty), with no source selection.
- R4: Register map. Address w in 0..3 holds the sources of queues 8w..8w+7, with queue q in the nibble at bit 4*(q%8); bit 3 of each nibble is reserved and reads 0. Addresses 4 and 5 are the lower and upper enable bitmaps. Addresses 6 and 7 are the lower and upper pending bitmaps. Queue q uses bit q%32 of its half.
- R5: A pending bit is never set while its enable bit is clear.
- R6: Writing to a pending address clears the bits written as one and leaves the bits written as zero unchanged. A clear wins over a set on the same clock.
- R7: A write to an enable address that turns a bit off also clears that queue's pending bit.
- R8: A pending bit that is cleared while its enabled condition still holds sets again on the next clock.
- R9: Each interrupt line is high exactly when any pending bit of its half is set.
- R10: A set pending bit stays set after its condition goes away, until it is cleared by a pending write or by disabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stat_lo_i | input | 128 | Four status flags per lower-half queue |
| ne_hi_i | input | 32 | Nearly-empty flag per upper-half queue |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Register read data, combinational |
| irq_lo_o | output | 1 | Interrupt for queues 0 to 31 |
| irq_hi_o | output | 1 | Interrupt for queues 32 to 63 |

## Verification
The hardest case to reach from the ports is a clear that lands on the same clock as a set while the condition is still active. Reaching it needs an enabled queue with a live condition, so that a pending write and a new set meet at one clock edge.

The bench holds an upper-half queue not nearly empty and enabled, then writes its pending bit. It reads zero just after that edge and one a clock later. The bench also walks all eight source codes with matching and non-matching flag patterns on a single lower-half queue, and disables the queue between vectors.

// File: rtl/qirq_pkg.sv
package qirq_pkg;
  localparam int DATA_W   = 32;
  localparam int FLAGS_Q  = 4;
  localparam int SRC_W    = 3;
  localparam int NIB_W    = 4;
  localparam int Q_PER_WD = DATA_W / NIB_W;
  typedef logic [SRC_W-1:0] src_code_t;
endpackage

// File: rtl/qirq_src_sel.sv
module qirq_src_sel
  import qirq_pkg::*;
#(
  parameter int N_Q = 32
) (
  input  src_code_t [N_Q-1:0]         src_i,
  input  logic      [N_Q*FLAGS_Q-1:0] stat_i,
  output logic      [N_Q-1:0]         cond_o
);
  for (genvar q = 0; q < N_Q; q++) begin : g_q
    logic [FLAGS_Q-1:0] flags;
    assign flags     = stat_i[q*FLAGS_Q +: FLAGS_Q];
    // low bits pick the flag, top bit inverts it
    assign cond_o[q] = flags[src_i[q][1:0]] ^ src_i[q][2];
  end
endmodule

// File: rtl/qirq_pend_half.sv
module qirq_pend_half #(
  parameter int N_Q = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_Q-1:0] cond_i,
  input  logic           en_wr_i,
  input  logic           pend_wr_i,
  input  logic [N_Q-1:0] wdata_i,
  output logic [N_Q-1:0] en_o,
  output logic [N_Q-1:0] pend_o,
  output logic           irq_o
);
  logic [N_Q-1:0] en_q, pend_q, clr;

  // write-1 clears, and so does turning an enable off
  assign clr = (pend_wr_i ? wdata_i : '0) | (en_wr_i ? ~wdata_i : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_wr_i) en_q <= wdata_i;
      pend_q <= (pend_q | (cond_i & en_q)) & ~clr;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = |pend_q;
endmodule

// File: rtl/qirq_agg.sv
module qirq_agg
  import qirq_pkg::*;
#(
  parameter  int HALF_Q    = 32,
  localparam int SRC_WORDS = HALF_Q / Q_PER_WD,
  localparam int ADDR_W    = $clog2(SRC_WORDS + 4)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [HALF_Q*FLAGS_Q-1:0] stat_lo_i,
  input  logic [HALF_Q-1:0]         ne_hi_i,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  output logic [DATA_W-1:0]         rd_data_o,
  output logic                      irq_lo_o,
  output logic                      irq_hi_o
);
  localparam logic [ADDR_W-1:0] A_EN_LO   = ADDR_W'(SRC_WORDS);
  localparam logic [ADDR_W-1:0] A_EN_HI   = ADDR_W'(SRC_WORDS + 1);
  localparam logic [ADDR_W-1:0] A_PEND_LO = ADDR_W'(SRC_WORDS + 2);
  localparam logic [ADDR_W-1:0] A_PEND_HI = ADDR_W'(SRC_WORDS + 3);

  src_code_t [HALF_Q-1:0] src_q;
  logic [HALF_Q-1:0] cond_lo, cond_hi;
  logic [HALF_Q-1:0] en_lo, en_hi, pend_lo, pend_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
    end else if (wr_en_i) begin
      for (int w = 0; w < SRC_WORDS; w++) begin
        if (wr_addr_i == ADDR_W'(w)) begin
          for (int j = 0; j < Q_PER_WD; j++)
            src_q[w*Q_PER_WD+j] <= wr_data_i[j*NIB_W +: SRC_W];
        end
      end
    end
  end

  qirq_src_sel #(.N_Q(HALF_Q)) u_sel (
    .src_i  (src_q),
    .stat_i (stat_lo_i),
    .cond_o (cond_lo)
  );

  assign cond_hi = ~ne_hi_i;

  qirq_pend_half #(.N_Q(HALF_Q)) u_lo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cond_i    (cond_lo),
    .en_wr_i   (wr_en_i && wr_addr_i == A_EN_LO),
    .pend_wr_i (wr_en_i && wr_addr_i == A_PEND_LO),
    .wdata_i   (wr_data_i[HALF_Q-1:0]),
    .en_o      (en_lo),
    .pend_o    (pend_lo),
    .irq_o     (irq_lo_o)
  );

  qirq_pend_half #(.N_Q(HALF_Q)) u_hi (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cond_i    (cond_hi),
    .en_wr_i   (wr_en_i && wr_addr_i == A_EN_HI),
    .pend_wr_i (wr_en_i && wr_addr_i == A_PEND_HI),
    .wdata_i   (wr_data_i[HALF_Q-1:0]),
    .en_o      (en_hi),
    .pend_o    (pend_hi),
    .irq_o     (irq_hi_o)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_EN_LO:   rd_data_o[HALF_Q-1:0] = en_lo;
      A_EN_HI:   rd_data_o[HALF_Q-1:0] = en_hi;
      A_PEND_LO: rd_data_o[HALF_Q-1:0] = pend_lo;
      A_PEND_HI: rd_data_o[HALF_Q-1:0] = pend_hi;
      default: begin
        for (int w = 0; w < SRC_WORDS; w++) begin
          if (rd_addr_i == ADDR_W'(w)) begin
            for (int j = 0; j < Q_PER_WD; j++)
              rd_data_o[j*NIB_W +: SRC_W] = src_q[w*Q_PER_WD+j];
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/qirq_agg_chk.sv
module qirq_agg_chk
  import qirq_pkg::*;
#(
  parameter  int HALF_Q    = 32,
  localparam int SRC_WORDS = HALF_Q / Q_PER_WD,
  localparam int ADDR_W    = $clog2(SRC_WORDS + 4)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [HALF_Q-1:0] ne_hi_i,
  input logic [HALF_Q-1:0] en_lo_i,
  input logic [HALF_Q-1:0] en_hi_i,
  input logic              irq_lo_i,
  input logic              irq_hi_i
);
  localparam logic [ADDR_W-1:0] A_EN_LO   = ADDR_W'(SRC_WORDS);
  localparam logic [ADDR_W-1:0] A_EN_HI   = ADDR_W'(SRC_WORDS + 1);
  localparam logic [ADDR_W-1:0] A_PEND_LO = ADDR_W'(SRC_WORDS + 2);
  localparam logic [ADDR_W-1:0] A_PEND_HI = ADDR_W'(SRC_WORDS + 3);

  AST_LO_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_lo_i) |-> $past(en_lo_i != '0)); // R5
  AST_HI_FIXED_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_hi_i) |-> $past((~ne_hi_i & en_hi_i) != '0)); // R3
  AST_LO_CLEAR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_PEND_LO && wr_data_i == '1) |=> !irq_lo_i); // R6
  AST_HI_CLEAR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_PEND_HI && wr_data_i == '1) |=> !irq_hi_i); // R6
  AST_LO_DISABLE_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_EN_LO && wr_data_i == '0) |=> !irq_lo_i); // R7
  AST_LO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_lo_i && !(wr_en_i && (wr_addr_i == A_PEND_LO || wr_addr_i == A_EN_LO)))
    |=> irq_lo_i); // R10
  AST_HI_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_hi_i && !(wr_en_i && (wr_addr_i == A_PEND_HI || wr_addr_i == A_EN_HI)))
    |=> irq_hi_i); // R10
endmodule

bind qirq_agg qirq_agg_chk #(.HALF_Q(HALF_Q)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .ne_hi_i   (ne_hi_i),
  .en_lo_i   (en_lo),
  .en_hi_i   (en_hi),
  .irq_lo_i  (irq_lo_o),
  .irq_hi_i  (irq_hi_o)
);

// File: tb/qirq_agg_bench.sv
`timescale 1ns/1ps
module qirq_agg_bench;
  localparam int A_EN_LO = 4, A_EN_HI = 5, A_PEND_LO = 6, A_PEND_HI = 7;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [127:0] stat_lo = '0;
  logic [31:0] ne_hi = '1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_lo, irq_hi;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  qirq_agg u_qirq_agg (
    .clk_i(clk), .rst_ni(rst_ni), .stat_lo_i(stat_lo), .ne_hi_i(ne_hi),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
  );

  // {code, flags[3:0], expected}, driven on lower queue 5
  localparam logic [7:0] VEC [12] = '{
    {3'd0, 4'b0001, 1'b1}, {3'd0, 4'b1110, 1'b0},
    {3'd1, 4'b0010, 1'b1}, {3'd2, 4'b0100, 1'b1},
    {3'd2, 4'b1011, 1'b0}, {3'd3, 4'b1000, 1'b1},
    {3'd4, 4'b0001, 1'b0}, {3'd4, 4'b0000, 1'b1},
    {3'd5, 4'b0010, 1'b0}, {3'd6, 4'b0000, 1'b1},
    {3'd7, 4'b1000, 1'b0}, {3'd7, 4'b0111, 1'b1}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    rd_addr = 3'(a);
    #1 d = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    step();
    chk("R1 irq_lo", 32'(irq_lo), 0);
    chk("R1 irq_hi", 32'(irq_hi), 0);
    for (int a = 0; a < 8; a++) begin
      rd(a, r);
      chk("R1 reg zero", r, 0);
    end

    // R2: walk all source codes on queue 5
    for (int v = 0; v < 12; v++) begin
      stat_lo = '0;
      stat_lo[5*4 +: 4] = VEC[v][4:1];
      wr(0, 32'(VEC[v][7:5]) << 20);
      wr(A_EN_LO, 32'h1 << 5);
      step();
      chk("R2 irq_lo", 32'(irq_lo), 32'(VEC[v][0]));
      rd(A_PEND_LO, r);
      chk("R2 pend bit", r, 32'(VEC[v][0]) << 5);
      wr(A_EN_LO, 0);
      chk("R7 disable clears", 32'(irq_lo), 0);
    end

    // R5: live condition, enable off
    stat_lo = '0; stat_lo[5*4] = 1'b1;
    wr(0, 0);
    step(); step();
    chk("R5 no enable", 32'(irq_lo), 0);

    // R4: source readback masks reserved bits
    wr(3, 32'hFFFF_FFFF);
    rd(3, r);
    chk("R4 reserved bits", r, 32'h7777_7777);
    wr(A_EN_HI, 32'h0000_0100);
    rd(A_EN_HI, r);
    chk("R4 enable hi", r, 32'h0000_0100);
    wr(3, 0);

    // R3: upper queue 40 triggers on not nearly empty
    step();
    chk("R3 nearly empty idle", 32'(irq_hi), 0);
    ne_hi[8] = 1'b0;
    step();
    chk("R3 irq_hi", 32'(irq_hi), 1);
    rd(A_PEND_HI, r);
    chk("R3 pend hi", r, 32'h0000_0100);

    // R10 sticky after condition drops
    ne_hi[8] = 1'b1;
    step(); step();
    chk("R10 sticky", 32'(irq_hi), 1);

    // R6 zeros leave bits, ones clear
    wr(A_PEND_HI, 32'hFFFF_FEFF);
    rd(A_PEND_HI, r);
    chk("R6 zero bits kept", r, 32'h0000_0100);
    wr(A_PEND_HI, 32'h0000_0100);
    step();
    chk("R6 cleared", 32'(irq_hi), 0);

    // R8 clear during live condition re-sets
    ne_hi[8] = 1'b0;
    step();
    wr(A_PEND_HI, 32'h0000_0100);
    rd(A_PEND_HI, r);
    chk("R6 clear wins", r, 0);
    step();
    rd(A_PEND_HI, r);
    chk("R8 re-set", r, 32'h0000_0100);

    // R7 upper disable clears, R5 stays clear
    wr(A_EN_HI, 0);
    chk("R7 hi disable", 32'(irq_hi), 0);
    step();
    chk("R5 hi off", 32'(irq_hi), 0);
    ne_hi = '1;

    // R9: two lower queues pending, OR behaviour
    stat_lo = '0;
    stat_lo[2*4+3] = 1'b1;
    stat_lo[9*4+3] = 1'b1;
    wr(0, 32'h0000_0300);
    wr(1, 32'h0000_0030);
    wr(A_EN_LO, 32'h0000_0204);
    step();
    stat_lo = '0;
    step();
    rd(A_PEND_LO, r);
    chk("R9 both pending", r, 32'h0000_0204);
    wr(A_PEND_LO, 32'h0000_0004);
    chk("R9 one left", 32'(irq_lo), 1);
    wr(A_PEND_LO, 32'h0000_0200);
    chk("R9 none left", 32'(irq_lo), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule